// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block collects interrupt events from client sources and stores each one as a fixed 32-byte vector of eight 32-bit dwords in a circular buffer in system memory. Software reads the buffer and drains it. The block owns the write pointer. Software owns the read pointer and programs it through a small register port. The buffer base address, the buffer size, the interrupt enable and an optional pointer-writeback address are programmed through the same port.

An event is accepted only while the ring is enabled and no earlier vector is still being written. The eight dwords then go out one per cycle on a plain memory write port. After the last dword the write pointer advances by 32 bytes and wraps at the buffer size. If the advanced pointer lands on the read pointer, the vector is still written, the old entry is overwritten, and a sticky overflow flag is set in bit 0 of the write-pointer word. When writeback is enabled, the updated write-pointer word is also stored at the writeback address in the following cycle. An interrupt line stays high while interrupts are enabled and unread data remains.

Top module: `ivr_producer`

## Requirements
- R1: After synchronous reset `wptr_mirror` is 0, `irq` is 0, `mem_we` is 0, and `evt_ready` is 0 because the ring is disabled.
- R2: `evt_ready` is high only while the ring enable (CTRL bit 0) is set and no vector or writeback is in progress. An event presented while the ring is disabled writes nothing and leaves `wptr_mirror` unchanged.
- R3: Dword 0 of a vector holds the client id in [7:0], the source id in [15:8], the ring id in [23:16], the VM id in [27:24] and the VM-id-source flag in bit 31. Bits [30:28] are 0.
- R4: Dword 1 holds timestamp [31:0]. Dword 2 holds timestamp [47:32] in [15:0] and the timestamp-source flag in bit 31. Its other bits are 0.
- R5: Dword 3 holds the PASID in [15:0] and the PASID-source flag in bit 31. Its other bits are 0. Dwords 4 to 7 hold data words 0 to 3, where data word k is `evt_data[32k+31:32k]`.
- R6: The eight dwords are written in order 0 to 7 in consecutive cycles, starting the cycle after acceptance. Dword k goes to byte address BASE + write pointer + 4k.
- R7: After the eighth dword the write pointer becomes (pointer + 32) AND mask. The mask is 2^(SIZE+2) − 1, where SIZE is CTRL[12:8] in dwords, clamped to the range 3 to MAX_LOG2. Pointers count bytes.
- R8: If the advanced pointer equals the masked read pointer, bit 0 of `wptr_mirror` is set and the vector is still written. The flag stays set until a CTRL write with bit 3 set, or a WPTR register write.
- R9: When writeback (CTRL bit 2) is enabled, the cycle after the eighth dword writes the updated write-pointer word to the WBADDR address. When writeback is disabled, no extra write occurs.
- R10: `irq` is high exactly when interrupts are enabled (CTRL bit 1) and either the overflow flag is set or the write pointer differs from the masked read pointer.
- R11: Register writes take effect at the next edge. CTRL is address 0. BASE is 1. RPTR is 2. WPTR is 3: it loads the pointer, aligned and masked, and clears the overflow flag. WBADDR is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event accepted when high together with evt_valid |
| evt_client | input | 8 | Client id |
| evt_source | input | 8 | Source id |
| evt_ring | input | 8 | Ring id |
| evt_vmid | input | 4 | VM id |
| evt_vmid_src | input | 1 | VM-id-source flag |
| evt_tstamp | input | 48 | Timestamp |
| evt_tstamp_src | input | 1 | Timestamp-source flag |
| evt_pasid | input | 16 | PASID |
| evt_pasid_src | input | 1 | PASID-source flag |
| evt_data | input | 128 | Four source data words |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write dword |
| wptr_mirror | output | 32 | Write pointer with overflow flag in bit 0 |
| irq | output | 1 | Interrupt line |

## Verification
Events with distinct values in every field separate field placement errors. Successive events in a four-entry ring walk the pointer through every slot up to the overflow point and then past it, which separates the overflow and wrap arithmetic from a plain increment. Runs with writeback on and off, and with interrupts on and off, show whether the extra write and the interrupt gating follow their enable bits. A final run after a size change and a software pointer reset checks that the wrap follows the new mask.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam int DW         = 32;
    localparam int VEC_DWORDS = 8;
    localparam int VEC_BYTES  = VEC_DWORDS * 4;
    localparam int SIZE_W     = 5;
    localparam int MIN_LOG2   = 3;

    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_BASE   = 3'd1;
    localparam logic [2:0] REG_RPTR   = 3'd2;
    localparam logic [2:0] REG_WPTR   = 3'd3;
    localparam logic [2:0] REG_WBADDR = 3'd4;

    localparam int CB_RING    = 0;
    localparam int CB_INT     = 1;
    localparam int CB_WB      = 2;
    localparam int CB_CLR     = 3;
    localparam int CB_SIZE_LO = 8;

    localparam logic [DW-1:0] ALIGN_MASK = ~DW'(VEC_BYTES - 1);

    typedef struct packed {
        logic [7:0]       client;
        logic [7:0]       source;
        logic [7:0]       ring;
        logic [3:0]       vmid;
        logic             vmid_src;
        logic [47:0]      tstamp;
        logic             tstamp_src;
        logic [15:0]      pasid;
        logic             pasid_src;
        logic [3:0][31:0] data;
    } ivr_event_t;

    typedef logic [VEC_DWORDS-1:0][DW-1:0] ivr_vec_t;

    typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_WB} ivr_state_e;

    function automatic ivr_vec_t pack_vector(ivr_event_t e);
        ivr_vec_t v;
        v[0] = {e.vmid_src, 3'b000, e.vmid, e.ring, e.source, e.client};
        v[1] = e.tstamp[31:0];
        v[2] = {e.tstamp_src, 15'd0, e.tstamp[47:32]};
        v[3] = {e.pasid_src, 15'd0, e.pasid};
        for (int k = 0; k < 4; k++) begin
            v[4+k] = e.data[k];
        end
        return v;
    endfunction

    function automatic logic [DW-1:0] ring_mask(logic [SIZE_W-1:0] lg, int max_lg);
        int eff;
        eff = int'(lg);
        if (eff < MIN_LOG2) eff = MIN_LOG2;
        if (eff > max_lg)   eff = max_lg;
        return DW'((64'd1 << (eff + 2)) - 64'd1);
    endfunction

endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2 = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic          ring_en,
    output logic          int_en,
    output logic          wb_en,
    output logic [DW-1:0] mask,
    output logic [DW-1:0] base,
    output logic [DW-1:0] wb_addr,
    output logic [DW-1:0] rptr,
    output logic          ovf_clr,
    output logic          sw_wptr_we,
    output logic [DW-1:0] sw_wptr
);

    logic [SIZE_W-1:0] size_lg;

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_en <= 1'b0;
            int_en  <= 1'b0;
            wb_en   <= 1'b0;
            size_lg <= '0;
            base    <= '0;
            wb_addr <= '0;
            rptr    <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL: begin
                    ring_en <= cfg_wdata[CB_RING];
                    int_en  <= cfg_wdata[CB_INT];
                    wb_en   <= cfg_wdata[CB_WB];
                    size_lg <= cfg_wdata[CB_SIZE_LO +: SIZE_W];
                end
                REG_BASE:   base    <= cfg_wdata;
                REG_RPTR:   rptr    <= cfg_wdata;
                REG_WBADDR: wb_addr <= cfg_wdata;
                default: ;
            endcase
        end
    end

    assign mask       = ring_mask(size_lg, MAX_LOG2);
    assign ovf_clr    = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[CB_CLR];
    assign sw_wptr_we = cfg_we && (cfg_addr == REG_WPTR);
    assign sw_wptr    = cfg_wdata;

endmodule

// File: rtl/ivr_wptr.sv
module ivr_wptr
    import ivr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] rptr,
    input  logic          ovf_clr,
    input  logic          sw_we,
    input  logic [DW-1:0] sw_val,
    output logic [DW-1:0] wptr_word,
    output logic          ovf,
    output logic          pending
);

    logic [DW-1:0] ptr;
    logic [DW-1:0] ptr_next;
    logic [DW-1:0] rptr_eff;
    logic          hit;

    assign rptr_eff = rptr & mask & ALIGN_MASK;
    assign ptr_next = (ptr + DW'(VEC_BYTES)) & mask;
    assign hit      = (ptr_next == rptr_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            ovf <= 1'b0;
        end else if (sw_we) begin
            ptr <= sw_val & mask & ALIGN_MASK;
            ovf <= 1'b0;
        end else begin
            if (advance) ptr <= ptr_next;
            if (advance && hit) ovf <= 1'b1;
            else if (ovf_clr)   ovf <= 1'b0;
        end
    end

    assign wptr_word = ptr | DW'(ovf);
    assign pending   = ovf || (ptr != rptr_eff);

    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(sw_we) && !$stable(ptr) && $stable(mask))
            |-> (ptr == (($past(ptr) + DW'(VEC_BYTES)) & mask))); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(ovf) && !$past(ovf_clr) && !$past(sw_we)) |-> ovf); // R8

endmodule

// File: rtl/ivr_emitter.sv
module ivr_emitter
    import ivr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ring_en,
    input  logic          wb_en,
    input  logic          evt_valid,
    input  ivr_event_t    evt,
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] wb_addr,
    input  logic [DW-1:0] ptr_word,
    output logic          evt_ready,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          advance
);

    localparam int IDX_W = $clog2(VEC_DWORDS);

    ivr_state_e       state;
    logic [IDX_W-1:0] idx;
    ivr_vec_t         vec;
    logic             last;

    assign last      = (idx == IDX_W'(VEC_DWORDS - 1));
    assign evt_ready = ring_en && (state == ST_IDLE);
    assign advance   = (state == ST_DATA) && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            vec   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (evt_valid && evt_ready) begin
                    vec   <= pack_vector(evt);
                    idx   <= '0;
                    state <= ST_DATA;
                end
                ST_DATA: begin
                    if (last) state <= wb_en ? ST_WB : ST_IDLE;
                    else      idx   <= idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (state == ST_DATA) begin
            mem_we    = 1'b1;
            mem_addr  = base + (ptr_word & ALIGN_MASK) + DW'({idx, 2'b00});
            mem_wdata = vec[idx];
        end else if (state == ST_WB) begin
            mem_we    = 1'b1;
            mem_addr  = wb_addr;
            mem_wdata = ptr_word;
        end
    end

    AST_WB_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (advance && wb_en) |=> (mem_we && mem_addr == wb_addr && mem_wdata == ptr_word)); // R9

endmodule

// File: rtl/ivr_producer.sv
module ivr_producer
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2 = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         evt_valid,
    output logic         evt_ready,
    input  logic [7:0]   evt_client,
    input  logic [7:0]   evt_source,
    input  logic [7:0]   evt_ring,
    input  logic [3:0]   evt_vmid,
    input  logic         evt_vmid_src,
    input  logic [47:0]  evt_tstamp,
    input  logic         evt_tstamp_src,
    input  logic [15:0]  evt_pasid,
    input  logic         evt_pasid_src,
    input  logic [127:0] evt_data,
    input  logic         cfg_we,
    input  logic [2:0]   cfg_addr,
    input  logic [31:0]  cfg_wdata,
    output logic         mem_we,
    output logic [31:0]  mem_addr,
    output logic [31:0]  mem_wdata,
    output logic [31:0]  wptr_mirror,
    output logic         irq
);

    ivr_event_t    evt;
    logic          ring_en, int_en, wb_en;
    logic [DW-1:0] mask, base, wb_addr, rptr, sw_wptr;
    logic          ovf_clr, sw_wptr_we, advance, ovf, pending;

    always_comb begin
        evt.client     = evt_client;
        evt.source     = evt_source;
        evt.ring       = evt_ring;
        evt.vmid       = evt_vmid;
        evt.vmid_src   = evt_vmid_src;
        evt.tstamp     = evt_tstamp;
        evt.tstamp_src = evt_tstamp_src;
        evt.pasid      = evt_pasid;
        evt.pasid_src  = evt_pasid_src;
        evt.data       = evt_data;
    end

    ivr_regs #(.MAX_LOG2(MAX_LOG2)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .ring_en(ring_en), .int_en(int_en), .wb_en(wb_en),
        .mask(mask), .base(base), .wb_addr(wb_addr), .rptr(rptr),
        .ovf_clr(ovf_clr), .sw_wptr_we(sw_wptr_we), .sw_wptr(sw_wptr)
    );

    ivr_wptr u_wptr (
        .clk(clk), .rst(rst),
        .advance(advance), .mask(mask), .rptr(rptr),
        .ovf_clr(ovf_clr), .sw_we(sw_wptr_we), .sw_val(sw_wptr),
        .wptr_word(wptr_mirror), .ovf(ovf), .pending(pending)
    );

    ivr_emitter u_emit (
        .clk(clk), .rst(rst),
        .ring_en(ring_en), .wb_en(wb_en),
        .evt_valid(evt_valid), .evt(evt),
        .base(base), .wb_addr(wb_addr), .ptr_word(wptr_mirror),
        .evt_ready(evt_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .advance(advance)
    );

    assign irq = int_en && pending;

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!ring_en && !mem_we) |=> !mem_we); // R2

    AST_OVF_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (ovf && int_en) |-> irq); // R10

endmodule

// File: tb/ivr_producer_bench.sv
module ivr_producer_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         evt_valid = 1'b0;
    logic         evt_ready;
    logic [7:0]   evt_client = '0, evt_source = '0, evt_ring = '0;
    logic [3:0]   evt_vmid = '0;
    logic         evt_vmid_src = 1'b0, evt_tstamp_src = 1'b0, evt_pasid_src = 1'b0;
    logic [47:0]  evt_tstamp = '0;
    logic [15:0]  evt_pasid = '0;
    logic [127:0] evt_data = '0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_addr = '0;
    logic [31:0]  cfg_wdata = '0;
    logic         mem_we;
    logic [31:0]  mem_addr, mem_wdata, wptr_mirror;
    logic         irq;

    always #10 clk = ~clk;

    ivr_producer u_ivr_producer (
        .clk(clk), .rst(rst),
        .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_client(evt_client), .evt_source(evt_source), .evt_ring(evt_ring),
        .evt_vmid(evt_vmid), .evt_vmid_src(evt_vmid_src),
        .evt_tstamp(evt_tstamp), .evt_tstamp_src(evt_tstamp_src),
        .evt_pasid(evt_pasid), .evt_pasid_src(evt_pasid_src),
        .evt_data(evt_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wptr_mirror(wptr_mirror), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_ring, m_int, m_wb, m_ovf;
    int unsigned m_lg, m_base, m_rptr, m_wptr, m_wbaddr;
    int unsigned q_addr[$];
    int unsigned q_data[$];
    string       q_tag[$];
    bit          q_last[$];

    function automatic int unsigned m_mask();
        int unsigned e;
        e = m_lg;
        if (e < 3)  e = 3;
        if (e > 16) e = 16;
        return (32'd1 << (e + 2)) - 1;
    endfunction

    function automatic int unsigned m_rp();
        return m_rptr & m_mask() & 32'hFFFF_FFE0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ring = 0; m_int = 0; m_wb = 0; m_ovf = 0;
            m_lg = 0; m_base = 0; m_rptr = 0; m_wptr = 0; m_wbaddr = 0;
            q_addr.delete(); q_data.delete(); q_tag.delete(); q_last.delete();
        end else begin
            bit rdy;
            rdy = m_ring && (q_addr.size() == 0);
            if (q_addr.size() > 0) begin
                bit lst;
                lst = q_last.pop_front();
                void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_tag.pop_front());
                if (lst) begin
                    int unsigned nxt;
                    nxt = (m_wptr + 32) & m_mask();
                    if (nxt == m_rp()) m_ovf = 1;
                    m_wptr = nxt;
                    if (m_wb) begin
                        q_addr.push_back(m_wbaddr); q_data.push_back(m_wptr | 32'(m_ovf));
                        q_tag.push_back("R9"); q_last.push_back(0);
                    end
                end
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: begin
                        m_ring = cfg_wdata[0]; m_int = cfg_wdata[1]; m_wb = cfg_wdata[2];
                        if (cfg_wdata[3]) m_ovf = 0;
                        m_lg = cfg_wdata[12:8];
                    end
                    3'd1: m_base = cfg_wdata;
                    3'd2: m_rptr = cfg_wdata;
                    3'd3: begin m_wptr = cfg_wdata & m_mask() & 32'hFFFF_FFE0; m_ovf = 0; end
                    3'd4: m_wbaddr = cfg_wdata;
                    default: ;
                endcase
            end
            if (evt_valid && rdy) begin
                int unsigned dw[8];
                dw[0] = {evt_vmid_src, 3'b000, evt_vmid, evt_ring, evt_source, evt_client};
                dw[1] = evt_tstamp[31:0];
                dw[2] = {evt_tstamp_src, 15'd0, evt_tstamp[47:32]};
                dw[3] = {evt_pasid_src, 15'd0, evt_pasid};
                for (int k = 0; k < 4; k++) dw[4+k] = evt_data[32*k +: 32];
                for (int k = 0; k < 8; k++) begin
                    q_addr.push_back(m_base + m_wptr + 4*k);
                    q_data.push_back(dw[k]);
                    q_tag.push_back(k == 0 ? "R3" : (k < 3 ? "R4" : "R5"));
                    q_last.push_back(k == 7);
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit e_we, e_rdy, e_irq;
            int unsigned e_wp;
            e_we  = (q_addr.size() > 0);
            e_rdy = m_ring && !e_we;
            e_wp  = m_wptr | 32'(m_ovf);
            e_irq = m_int && (m_ovf || (m_wptr != m_rp()));
            chk(evt_ready == e_rdy, "R2", 64'(evt_ready), 64'(e_rdy));
            chk(mem_we == e_we, "R6", 64'(mem_we), 64'(e_we));
            if (mem_we && e_we) begin
                chk(mem_addr == q_addr[0], (q_tag[0] == "R9") ? "R9" : "R6",
                    64'(mem_addr), 64'(q_addr[0]));
                chk(mem_wdata == q_data[0], q_tag[0], 64'(mem_wdata), 64'(q_data[0]));
            end
            chk(wptr_mirror == e_wp, "R7", 64'(wptr_mirror), 64'(e_wp));
            chk(irq == e_irq, "R10", 64'(irq), 64'(e_irq));
        end
    end

    // ---------------- stimulus ----------------
    task automatic cfg_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_evt(int seed);
        @(negedge clk);
        evt_client     = 8'(8'h10 + seed);
        evt_source     = 8'(8'h40 + 3*seed);
        evt_ring       = 8'(8'hA0 ^ seed);
        evt_vmid       = 4'(seed + 5);
        evt_vmid_src   = seed[0];
        evt_tstamp     = 48'h1234_5678_9ABC + 48'(seed * 1111);
        evt_tstamp_src = ~seed[0];
        evt_pasid      = 16'(16'hBEE0 + seed);
        evt_pasid_src  = seed[1];
        evt_data       = {32'(32'hD3000000 + seed), 32'(32'hD2000000 + seed),
                          32'(32'hD1000000 + seed), 32'(32'hD0000000 + seed)};
        evt_valid      = 1'b1;
        while (!evt_ready) @(negedge clk);
        @(negedge clk);
        evt_valid = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    function automatic logic [31:0] ctrl(bit ring, bit ien, bit wb, bit clr, int lg);
        return {19'd0, 5'(lg), 4'd0, clr, wb, ien, ring};
    endfunction

    task automatic summary();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(wptr_mirror == 0 && !irq && !mem_we && !evt_ready, "R1",
            {wptr_mirror, 29'd0, irq, mem_we, evt_ready}, 64'd0);

        // R2 events ignored while ring disabled
        evt_valid = 1'b1;
        repeat (5) @(negedge clk);
        evt_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(wptr_mirror == 0 && !mem_we, "R2", 64'(wptr_mirror), 64'd0);

        cfg_write(3'd1, 32'h0000_1000);
        cfg_write(3'd4, 32'h0000_2000);
        cfg_write(3'd2, 32'h0);
        cfg_write(3'd0, ctrl(1, 1, 1, 0, 5));

        send_evt(1);
        chk(wptr_mirror == 32'h20 && irq, "R7", 64'(wptr_mirror), 64'h20);
        send_evt(2);
        send_evt(3);
        chk(wptr_mirror == 32'h60, "R7", 64'(wptr_mirror), 64'h60);
        send_evt(4);
        chk(wptr_mirror == 32'h01, "R8", 64'(wptr_mirror), 64'h01);
        send_evt(5);
        chk(wptr_mirror == 32'h21, "R8", 64'(wptr_mirror), 64'h21);
        cfg_write(3'd0, ctrl(1, 1, 1, 1, 5));
        @(negedge clk);
        chk(wptr_mirror == 32'h20, "R8", 64'(wptr_mirror), 64'h20);

        cfg_write(3'd2, 32'h20);
        @(negedge clk);
        chk(!irq, "R10", 64'(irq), 64'd0);
        cfg_write(3'd0, ctrl(1, 0, 1, 0, 5));
        cfg_write(3'd2, 32'h0);
        @(negedge clk);
        chk(!irq, "R10", 64'(irq), 64'd0);

        cfg_write(3'd0, ctrl(1, 1, 0, 0, 5));
        send_evt(6);
        chk(wptr_mirror == 32'h40 && irq, "R9", 64'(wptr_mirror), 64'h40);

        cfg_write(3'd3, 32'h0);
        cfg_write(3'd2, 32'h0);
        @(negedge clk);
        chk(wptr_mirror == 0 && !irq, "R11", {wptr_mirror, 31'd0, irq}, 64'd0);

        cfg_write(3'd0, ctrl(1, 1, 1, 0, 4));
        send_evt(7);
        chk(wptr_mirror == 32'h20, "R7", 64'(wptr_mirror), 64'h20);
        send_evt(8);
        chk(wptr_mirror == 32'h01, "R8", 64'(wptr_mirror), 64'h01);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule